// File: doc/BRIEF.md
# Staged Multi-Channel Output Word Bank

This block drives a fixed set of downstream channels, each with its own output word, from a single write-only parallel bus. The bus has one data word, one channel address and one write strobe. A write places its data in a staging register that belongs to the addressed channel. That channel's visible output does not change when the write happens.

A separate commit pulse copies every staging register into its channel's output register on one clock edge, so all channel outputs change in the same cycle. A controller can therefore load the next set of values channel by channel, over as many cycles as it needs. It then fires one commit to switch every output at once. The outputs keep their values between commits.

Top module: `staged_word_bank`

## Requirements
- R1: The bank has NUM_CH channels (default 40) of DATA_W bits (default 14). Channel k appears on `out_flat[k*DATA_W +: DATA_W]`.
- R2: When `wr_en` is high and `wr_addr` is below NUM_CH, the rising edge loads `wr_data` into the staging register of channel `wr_addr`. The value becomes visible on the outputs after the next commit.
- R3: Each cycle writes at most one staging register. While `wr_en` is low, no staging register changes.
- R4: When `commit` is high, every output register takes its channel's staging value on the same rising edge, so all outputs are visible one cycle after the commit.
- R5: While `commit` is low, every output word holds its value, whatever writes occur.
- R6: A write to address values NUM_CH through 2^ADDR_W-1 (40 to 63 by default) changes no staging and no output register.
- R7: When synchronous reset `rst` is high, all staging and output registers clear to zero on the rising edge.
- R8: When a write and `commit` occur in the same cycle, the outputs take the staging values held before that write. The written value reaches the outputs only at a later commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_addr | input | ADDR_W (6) | Channel address for the write |
| wr_data | input | DATA_W (14) | Data word shared by all staging registers |
| commit | input | 1 | Copies all staging registers into the output registers |
| out_flat | output | NUM_CH*DATA_W (560) | Concatenated channel output words, channel 0 at the LSBs |

## Verification
The bench builds the block with its default parameters: 40 channels, 14-bit words and a 6-bit address. With these values the 24 unused addresses (40 to 63) can be driven, and the last channel's slice sits at the top of the output vector. Every channel receives a distinct word before a commit, so a slice misplaced by the decoder or the flattening shows up. The same-cycle write-and-commit case and a reset issued with staging data pending are driven directly.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // Bit position of the least significant bit of channel k's slice
  function automatic int chan_lsb(input int k, input int width);
    return k * width;
  endfunction

  // True when a channel address refers to an implemented channel
  function automatic logic addr_in_range(input int addr, input int n_ch);
    return (addr >= 0) && (addr < n_ch);
  endfunction
endpackage

// File: rtl/swb_decode.sv
module swb_decode #(
  parameter int NUM_CH = 40,
  parameter int ADDR_W = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CH-1:0] sel
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign sel[k] = wr_en && (wr_addr == ADDR_W'(k));
  end
endmodule

// File: rtl/swb_channel.sv
module swb_channel #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              commit,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (load)   stage_q <= din;
      if (commit) out_q   <= stage_q;
    end
  end
endmodule

// File: rtl/staged_word_bank.sv
module staged_word_bank
  import swb_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int DATA_W = 14,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     commit,
  output logic [NUM_CH*DATA_W-1:0] out_flat
);
  localparam int FLAT_W = NUM_CH * DATA_W;

  // Named internal events for the checker
  logic [NUM_CH-1:0] sel_vec;
  logic              addr_hit;
  logic [FLAT_W-1:0] stage_flat;

  swb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .sel    (sel_vec)
  );

  assign addr_hit = |sel_vec;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int LSB = chan_lsb(k, DATA_W);
    swb_channel #(.DATA_W(DATA_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .load   (sel_vec[k]),
      .commit (commit),
      .din    (wr_data),
      .stage_q(stage_flat[LSB +: DATA_W]),
      .out_q  (out_flat[LSB +: DATA_W])
    );
  end
endmodule

// File: rtl/swb_checker.sv
module swb_checker
  import swb_pkg::*;
#(
  parameter int NUM_CH = 40,
  parameter int DATA_W = 14,
  parameter int ADDR_W = 6
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [DATA_W-1:0]        wr_data,
  input logic                     commit,
  input logic [NUM_CH-1:0]        sel_vec,
  input logic                     addr_hit,
  input logic [NUM_CH*DATA_W-1:0] stage_flat,
  input logic [NUM_CH*DATA_W-1:0] out_flat
);
  logic              bad_wr;
  logic              last_ok;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_data;
  logic [DATA_W-1:0] stage_at_last;

  assign bad_wr = wr_en && !addr_in_range(int'(wr_addr), NUM_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_ok   <= 1'b0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      last_ok   <= wr_en && addr_in_range(int'(wr_addr), NUM_CH);
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  always_comb begin
    stage_at_last = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (int'(last_addr) == k)
        stage_at_last = stage_flat[chan_lsb(k, DATA_W) +: DATA_W];
  end

  // R3: the decode selects at most one channel
  p_one_target_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));

  // R3: a cycle with the strobe low leaves every staging register as it was
  p_idle_no_write_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(stage_flat));

  // R2: a valid write lands in the addressed staging register
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    last_ok |-> stage_at_last == last_data);

  // R4, R8: a commit copies the staging values held before that edge
  p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
    commit |=> out_flat == $past(stage_flat));

  // R5: outputs hold when there is no commit
  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(out_flat));

  // R6: out-of-range addresses hit nothing
  p_bad_addr_r6: assert property (@(posedge clk) disable iff (rst)
    bad_wr |-> !addr_hit);

  p_bad_addr_stage_r6: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> $stable(stage_flat));

  // R7: reset clears all storage
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (out_flat == '0) && (stage_flat == '0));
endmodule

bind staged_word_bank swb_checker #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .commit(commit), .sel_vec(sel_vec), .addr_hit(addr_hit),
  .stage_flat(stage_flat), .out_flat(out_flat)
);

// File: tb/sim_staged_word_bank.sv
`timescale 1ns/1ps
module sim_staged_word_bank;
  localparam int NCH = 40;
  localparam int DW  = 14;
  localparam int AW  = 6;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          cmt;
    logic [3:0]    req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd0,  14'h1234, 1'b0, 4'd5}, // R5: staged, outputs stay 0
    '{1'b1, 6'd39, 14'h3FFF, 1'b0, 4'd2}, // R2: last channel
    '{1'b1, 6'd17, 14'h0ABC, 1'b0, 4'd2},
    '{1'b0, 6'd0,  14'h0000, 1'b1, 4'd4}, // R4: commit all
    '{1'b1, 6'd0,  14'h0001, 1'b0, 4'd5}, // R5
    '{1'b1, 6'd40, 14'h2222, 1'b0, 4'd6}, // R6
    '{1'b1, 6'd63, 14'h1111, 1'b0, 4'd6}, // R6
    '{1'b0, 6'd0,  14'h0000, 1'b1, 4'd6}, // R6: only ch0 changes
    '{1'b1, 6'd5,  14'h0555, 1'b1, 4'd8}, // R8: same-cycle write and commit
    '{1'b0, 6'd0,  14'h0000, 1'b0, 4'd5},
    '{1'b0, 6'd0,  14'h0000, 1'b1, 4'd8}, // R8: value arrives now
    '{1'b0, 6'd3,  14'h3333, 1'b0, 4'd3}, // R3: strobe low
    '{1'b0, 6'd0,  14'h0000, 1'b1, 4'd3}, // R3: nothing new committed
    '{1'b1, 6'd39, 14'h2AAA, 1'b1, 4'd8}  // R8
  };

  logic clk = 1'b0;
  logic rst, wr_en, commit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NCH*DW-1:0] out_flat;

  int n_checks = 0;
  int n_fail = 0;
  logic [DW-1:0] m_stage [NCH];
  logic [DW-1:0] m_out [NCH];

  always #4 clk = ~clk;

  staged_word_bank #(.NUM_CH(NCH), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .out_flat(out_flat)
  );

  function automatic logic [NCH*DW-1:0] model_flat();
    logic [NCH*DW-1:0] f = '0;
    for (int c = NCH-1; c >= 0; c--) f = (f << DW) | {{(NCH*DW-DW){1'b0}}, m_out[c]};
    return f;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin m_stage[c] = '0; m_out[c] = '0; end
  endtask

  task automatic check_all(input string tag);
    logic [NCH*DW-1:0] exp_v = model_flat();
    n_checks++;
    if (out_flat !== exp_v) begin
      n_fail++;
      $display("FAIL %s: out_flat=%h expected=%h", tag, out_flat, exp_v);
    end
  endtask

  // Drive at negedge, clock it in, update the model, compare at next negedge
  task automatic step(input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic c);
    wr_en = w; wr_addr = a; wr_data = d; commit = c;
    @(posedge clk);
    if (c) for (int k = 0; k < NCH; k++) m_out[k] = m_stage[k];
    if (w && int'(a) < NCH) m_stage[a] = d;
    @(negedge clk);
    wr_en = 1'b0; commit = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; commit = 1'b0; wr_addr = '0; wr_data = '0;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #1600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check_all("R7 reset state");

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].cmt);
      check_all($sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R1: distinct word per channel, commit, then check every slice
    for (int c = 0; c < NCH; c++) step(1'b1, AW'(c), DW'(c * 331 + 7), 1'b0);
    check_all("R5 all staged, outputs unchanged");
    step(1'b0, '0, '0, 1'b1);
    for (int c = 0; c < NCH; c++) begin
      n_checks++;
      if (out_flat[c*DW +: DW] !== DW'(c * 331 + 7)) begin
        n_fail++;
        $display("FAIL R1 channel %0d: got %h expected %h",
                 c, out_flat[c*DW +: DW], DW'(c * 331 + 7));
      end
    end

    // R6: every unused address, then commit, nothing moves
    for (int a = NCH; a < (1 << AW); a++) step(1'b1, AW'(a), 14'h3C3C, 1'b0);
    step(1'b0, '0, '0, 1'b1);
    check_all("R6 sweep of unused addresses");

    // R7: reset with pending staging data, then commit shows zeros
    step(1'b1, 6'd12, 14'h1F1F, 1'b0);
    do_reset();
    check_all("R7 mid-run reset outputs");
    step(1'b0, '0, '0, 1'b1);
    check_all("R7 staging cleared by reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule